// File: doc/BRIEF.md
# Single-Accumulator 16-Bit Processor Core

This block is a small multi-cycle processor built around one 16-bit accumulator. It fetches 16-bit instructions from a shared memory over a single bus and executes them. Each instruction carries a 4-bit operation code in its upper bits and a 12-bit operand in its lower bits. The operand is an immediate value, a direct address or the address of a pointer. The memory is outside the block. The bus presents the read word combinationally in the same cycle that the core drives an enabled read, and it captures a write on the clock edge that closes an enabled write cycle.

Internally the core keeps a program counter, an instruction register, a pointer register used by the indirect operations, and the accumulator. A control state machine moves through a fetch cycle and an execute cycle for every instruction. Indirect loads and stores add a third cycle that uses the fetched pointer. A halt instruction parks the core until reset and raises a status output.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and in the cycle after it is released, `halted` is 0 and the core drives an enabled read (`mem_en`=1, `mem_we`=0) at address 0. The program counter and accumulator start at zero.
- R2: Each fetch reads the word at the program counter, which then advances by one. Bits 15:12 of the word are the operation code and bits 11:0 are the operand.
- R3: Word 0x0000 halts the core. `halted` rises after the execute cycle and stays at 1 until reset, and no memory cycle is issued while it is 1.
- R4: Word 0x0001 replaces the accumulator with its two's-complement negation.
- R5: Code 1 loads the 12-bit operand, zero-extended, into the accumulator.
- R6: Code 2 loads the accumulator from the word at the operand address. Code 0xA adds that word to the accumulator, modulo 2^16.
- R7: Code 3 reads a pointer from the operand address and then loads the accumulator from the address in the pointer's low 12 bits. The pointer's upper 4 bits are ignored.
- R8: Code 4 writes the accumulator to the operand address.
- R9: Code 5 reads a pointer from the operand address and writes the accumulator to the address in the pointer's low 12 bits.
- R10: Code 6 always loads the program counter with the operand.
- R11: Codes 7, 8 and 9 load the program counter with the operand only when the accumulator, read as two's complement, is zero, greater than zero or less than zero respectively. When the test fails, execution goes on with the next word.
- R12: Codes 0xB to 0xF, and words 0x0002 to 0x0FFF, change neither the accumulator nor memory.
- R13: Every instruction takes two cycles (fetch and execute). Codes 3 and 5 take three. A write cycle is always followed by a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_en | output | 1 | Memory cycle request for this clock |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | 16 | Word address, upper 4 bits always zero |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the request |
| halted | output | 1 | Core has executed halt |

## Verification
Every result is due a fixed number of cycles after reset is released: two cycles for each plain instruction and three for each indirect one. The bench therefore predicts the total run length of each program from its instruction mix. It counts rising edges until `halted` is seen at a falling edge and compares the count exactly. Accumulator values are brought out by store instructions and read from the bench memory only after the core has halted, so every memory check comes after the last write has settled. The checks on halt quietness and the reset-state bus sample on falling edges, away from every active edge.

// File: rtl/acc_cpu_pkg.sv
// Package: shared encodings for the accumulator core.
// Assumes a 4-bit operation code in the top bits of each instruction word.
package acc_cpu_pkg;

    localparam logic [3:0] OP_SYS = 4'h0;
    localparam logic [3:0] OP_LDI = 4'h1;
    localparam logic [3:0] OP_LD  = 4'h2;
    localparam logic [3:0] OP_LDN = 4'h3;
    localparam logic [3:0] OP_ST  = 4'h4;
    localparam logic [3:0] OP_STN = 4'h5;
    localparam logic [3:0] OP_JMP = 4'h6;
    localparam logic [3:0] OP_JZ  = 4'h7;
    localparam logic [3:0] OP_JP  = 4'h8;
    localparam logic [3:0] OP_JN  = 4'h9;
    localparam logic [3:0] OP_ADD = 4'hA;

    typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_IND, ST_HALT} state_e;

    typedef enum logic [2:0] {ACC_HOLD, ACC_NEG, ACC_IMM, ACC_MEM, ACC_ADD} acc_op_e;

    typedef enum logic [1:0] {ADR_PC, ADR_IR, ADR_IAR} adr_src_e;

    typedef struct packed {
        logic     ir_ld;
        logic     pc_inc;
        logic     pc_ld;
        logic     iar_ld;
        acc_op_e  acc_op;
        adr_src_e adr_src;
        logic     mem_en;
        logic     mem_we;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_ctrl.sv
// Module: control state machine. Sequences fetch, execute and the extra
// pointer cycle, and decodes the operation into datapath controls.
// Assumes opcode and operand come from the registered instruction word.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int ARG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       opcode,
    input  logic [ARG_W-1:0] arg,
    input  logic             acc_zero,
    input  logic             acc_neg,
    output ctl_t             ctl,
    output state_e           state,
    output logic             halted
);

    state_e nxt;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nxt;
    end

    // Next state and control decode.
    always_comb begin
        ctl = '0;
        ctl.acc_op  = ACC_HOLD;
        ctl.adr_src = ADR_PC;
        nxt = state;
        case (state)
            ST_FETCH: begin
                ctl.mem_en = 1'b1;
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
                nxt        = ST_EXEC;
            end
            ST_EXEC: begin
                nxt         = ST_FETCH;
                ctl.adr_src = ADR_IR;
                case (opcode)
                    OP_SYS: begin
                        if (arg == '0)                nxt = ST_HALT;
                        else if (arg == ARG_W'(1))    ctl.acc_op = ACC_NEG;
                    end
                    OP_LDI: ctl.acc_op = ACC_IMM;
                    OP_LD: begin
                        ctl.mem_en = 1'b1;
                        ctl.acc_op = ACC_MEM;
                    end
                    OP_LDN, OP_STN: begin
                        ctl.mem_en = 1'b1;
                        ctl.iar_ld = 1'b1;
                        nxt        = ST_IND;
                    end
                    OP_ST: begin
                        ctl.mem_en = 1'b1;
                        ctl.mem_we = 1'b1;
                    end
                    OP_JMP: ctl.pc_ld = 1'b1;
                    OP_JZ:  ctl.pc_ld = acc_zero;
                    OP_JP:  ctl.pc_ld = !acc_zero && !acc_neg;
                    OP_JN:  ctl.pc_ld = acc_neg;
                    OP_ADD: begin
                        ctl.mem_en = 1'b1;
                        ctl.acc_op = ACC_ADD;
                    end
                    default: ;
                endcase
            end
            ST_IND: begin
                nxt         = ST_FETCH;
                ctl.adr_src = ADR_IAR;
                ctl.mem_en  = 1'b1;
                if (opcode == OP_LDN) ctl.acc_op = ACC_MEM;
                else                  ctl.mem_we = 1'b1;
            end
            default: nxt = ST_HALT;
        endcase
    end

    assign halted = (state == ST_HALT);

endmodule

// File: rtl/acc_cpu_alu.sv
// Module: accumulator next-value logic.
// Assumes memory data is valid whenever a memory operation is selected.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ARG_W  = 12
) (
    input  acc_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [ARG_W-1:0]  imm,
    input  logic [DATA_W-1:0] mdata,
    output logic [DATA_W-1:0] nxt
);

    // Select the new accumulator value.
    always_comb begin
        case (op)
            ACC_NEG: nxt = -acc;
            ACC_IMM: nxt = DATA_W'(imm);
            ACC_MEM: nxt = mdata;
            ACC_ADD: nxt = acc + mdata;
            default: nxt = acc;
        endcase
    end

endmodule

// File: rtl/acc_cpu_dp.sv
// Module: datapath registers (program counter, instruction, pointer,
// accumulator) and the address multiplexer.
// Assumes control arrives from acc_cpu_ctrl in the same cycle.
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [3:0]        opcode,
    output logic [DATA_W-OPC_W-1:0] arg,
    output logic              acc_zero,
    output logic              acc_neg
);

    localparam int ARG_W = DATA_W - OPC_W;

    logic [ARG_W-1:0]  pc, iar, adr;
    logic [DATA_W-1:0] ir, acc, acc_nxt;

    acc_cpu_alu #(.DATA_W(DATA_W), .ARG_W(ARG_W)) u_alu (
        .op    (ctl.acc_op),
        .acc   (acc),
        .imm   (arg),
        .mdata (mem_rdata),
        .nxt   (acc_nxt)
    );

    // Program counter: jump target has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (ctl.pc_ld)  pc <= arg;
        else if (ctl.pc_inc) pc <= pc + 1'b1;
    end

    // Instruction, pointer and accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir  <= '0;
            iar <= '0;
            acc <= '0;
        end else begin
            if (ctl.ir_ld)  ir  <= mem_rdata;
            if (ctl.iar_ld) iar <= mem_rdata[ARG_W-1:0];
            acc <= acc_nxt;
        end
    end

    // Address source selection.
    always_comb begin
        case (ctl.adr_src)
            ADR_IR:  adr = arg;
            ADR_IAR: adr = iar;
            default: adr = pc;
        endcase
    end

    assign opcode    = ir[DATA_W-1 -: 4];
    assign arg       = ir[ARG_W-1:0];
    assign mem_addr  = DATA_W'(adr);
    assign mem_wdata = acc;
    assign acc_zero  = (acc == '0);
    assign acc_neg   = acc[DATA_W-1];

endmodule

// File: rtl/acc_cpu.sv
// Module: top of the accumulator core; joins control and datapath.
// Assumes a memory that returns read data in the cycle of the request.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    localparam int ARG_W = DATA_W - OPC_W;

    ctl_t             ctl;
    state_e           state;
    logic [3:0]       opcode;
    logic [ARG_W-1:0] arg;
    logic             acc_zero, acc_neg;
    logic             fetch;

    acc_cpu_ctrl #(.ARG_W(ARG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .arg      (arg),
        .acc_zero (acc_zero),
        .acc_neg  (acc_neg),
        .ctl      (ctl),
        .state    (state),
        .halted   (halted)
    );

    acc_cpu_dp #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode),
        .arg       (arg),
        .acc_zero  (acc_zero),
        .acc_neg   (acc_neg)
    );

    assign mem_en = ctl.mem_en;
    assign mem_we = ctl.mem_we;
    assign fetch  = (state == ST_FETCH);

endmodule

// File: rtl/acc_cpu_chk.sv
// Module: bus and sequencing properties of the accumulator core,
// attached to acc_cpu through bind.
module acc_cpu_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_en,
    input logic mem_we,
    input logic halted,
    input logic fetch
);

    assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_en);

    assert_fetch_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> (mem_en && !mem_we));

    assert_write_enabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    assert_fetch_not_repeated_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> !fetch);

    assert_write_then_fetch_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> fetch);

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_en (mem_en),
    .mem_we (mem_we),
    .halted (halted),
    .fetch  (fetch)
);

// File: tb/acc_cpu_test.sv
// Bench: runs short programs from a 256-word model memory and checks
// stored results and exact run lengths against arithmetic predictions.
module acc_cpu_test;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en, mem_we, halted;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] mem [256];
    int          checks = 0;
    int          failures = 0;

    always #(CLK_NS/2) clk = ~clk;

    acc_cpu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // Model memory: combinational read, write on the closing edge.
    always @(posedge clk) if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
    endtask

    // Reset, release, and count edges until halted is seen.
    task automatic run(input int exp_cyc, input string req);
        int cyc;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        check(cyc == exp_cyc, req, "cycle count", 16'(cyc), 16'(exp_cyc));
    endtask

    initial begin
        #(CLK_NS * 150000);
        checks++;
        failures++;
        $display("FAIL R13 watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int quiet;
        logic [15:0] v, w, w2, d, exp_code;
        int exp_cyc;

        // R1: reset state on the bus.
        clear_mem();
        repeat (3) @(negedge clk);
        check(halted == 1'b0, "R1", "halted in reset", 16'(halted), 16'h0);
        check(mem_en && !mem_we, "R1", "fetch read in reset", {14'h0, mem_en, mem_we}, 16'h2);
        check(mem_addr == 16'h0, "R1", "first address", mem_addr, 16'h0);

        // R3: halt at address 0 takes two cycles, then bus stays quiet.
        run(2, "R3");
        quiet = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_en) quiet++;
            if (!halted) quiet++;
        end
        check(quiet == 0, "R3", "activity after halt", 16'(quiet), 16'h0);

        // R2 R4 R5 R6 R8: immediate, negate, add and direct load sweep.
        for (int i = 0; i < 48; i++) begin
            v  = 16'((i * 695 + 3) & 16'h0FFF);
            w  = 16'(i * 40503 + 17);
            w2 = 16'(i * 9001) ^ 16'hA5C3;
            clear_mem();
            mem[0] = 16'h1000 | v;
            mem[1] = 16'h4080;
            mem[2] = 16'h0001;
            mem[3] = 16'h4081;
            mem[4] = 16'hA082;
            mem[5] = 16'h4083;
            mem[6] = 16'h2084;
            mem[7] = 16'h4085;
            mem[8] = 16'h0000;
            mem[8'h82] = w;
            mem[8'h84] = w2;
            run(18, "R2");
            check(mem[8'h80] == v, "R5", "immediate zero-extended", mem[8'h80], v);
            check(mem[8'h81] == 16'(-v), "R4", "negation", mem[8'h81], 16'(-v));
            check(mem[8'h83] == 16'(w - v), "R6", "add", mem[8'h83], 16'(w - v));
            check(mem[8'h85] == w2, "R8", "direct load/store", mem[8'h85], w2);
        end

        // R7 R9 R13: indirect load and store; pointer upper bits ignored.
        for (int i = 0; i < 16; i++) begin
            w = 16'(i * 3121 + 9);
            clear_mem();
            mem[0] = 16'h3090;
            mem[1] = 16'h5091;
            mem[2] = 16'h0000;
            mem[8'h90] = 16'hF0A0;
            mem[8'hA0] = w;
            mem[8'h91] = 16'h00B0;
            run(8, "R13");
            check(mem[8'hB0] == w, "R7", "indirect load then R9 indirect store", mem[8'hB0], w);
            check(mem[8'hA0] == w, "R9", "source word untouched", mem[8'hA0], w);
        end

        // R11: conditional branch sweep on the accumulator sign.
        for (int i = 0; i < 40; i++) begin
            case (i)
                0: d = 16'h0000;
                1: d = 16'h0001;
                2: d = 16'h7FFF;
                3: d = 16'h8000;
                4: d = 16'hFFFF;
                default: d = 16'(i * 5077);
            endcase
            clear_mem();
            mem[0] = 16'h20C0;
            mem[1] = 16'h7010;
            mem[2] = 16'h8020;
            mem[3] = 16'h9030;
            mem[4] = 16'h100F;
            mem[5] = 16'h40D0;
            mem[8'h10] = 16'h1001; mem[8'h11] = 16'h40D0;
            mem[8'h20] = 16'h1002; mem[8'h21] = 16'h40D0;
            mem[8'h30] = 16'h1003; mem[8'h31] = 16'h40D0;
            mem[8'hC0] = d;
            if (d == 16'h0)   begin exp_code = 16'h1; exp_cyc = 10; end
            else if (!d[15])  begin exp_code = 16'h2; exp_cyc = 12; end
            else              begin exp_code = 16'h3; exp_cyc = 14; end
            run(exp_cyc, "R11");
            check(mem[8'hD0] == exp_code, "R11", "branch taken", mem[8'hD0], exp_code);
        end

        // R10: unconditional jump skips words 1..4.
        clear_mem();
        mem[0] = 16'h6005;
        mem[1] = 16'h1111;
        mem[2] = 16'h40D0;
        mem[5] = 16'h1222;
        mem[6] = 16'h40D0;
        run(8, "R10");
        check(mem[8'hD0] == 16'h0222, "R10", "jump target", mem[8'hD0], 16'h0222);

        // R12: undefined codes touch neither accumulator nor memory.
        clear_mem();
        mem[0] = 16'h1ABC;
        mem[1] = 16'hB0E0;
        mem[2] = 16'hC0E0;
        mem[3] = 16'hD0E0;
        mem[4] = 16'hE0E0;
        mem[5] = 16'hF0E0;
        mem[6] = 16'h0002;
        mem[7] = 16'h0FFF;
        mem[8] = 16'h40D0;
        mem[8'hE0] = 16'h5A5A;
        run(20, "R12");
        check(mem[8'hD0] == 16'h0ABC, "R12", "accumulator kept", mem[8'hD0], 16'h0ABC);
        check(mem[8'hE0] == 16'h5A5A, "R12", "memory kept", mem[8'hE0], 16'h5A5A);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule